// File: doc/BRIEF.md
# Operand-Isolated Dual-Adder Result Path

This block is a small datapath with two adders whose results compete, through a chain of two result-select multiplexers, for a single registered output. The first adder forms `in_a + in_b`. A middle multiplexer picks that sum or the bypass word `in_c`. The second adder adds a masked copy of `in_d` to `in_e`. The `in_d` copy is already forced to zero by the middle select when that select is low. The final multiplexer chooses between the second adder and the middle word. Its select, the route signal, comes from selection logic. That logic combines two steering inputs with a local addition of `in_c` and `in_f`.

To save switching power, each adder's operands pass through AND-style isolation gates placed directly in front of the adder. An isolated operand is driven to all zeros whenever the adder's result cannot reach the output. The parameter `STYLE` picks how the gate enables are built. In the fine style they come from the observability of each adder at the output, using the middle select and the route signal. In the coarse style they are primary inputs used as they are, with no derivation logic. The operand taps are brought out as ports so that the isolation activity can be observed. Isolation never changes the registered result.

Top module: `opiso_datapath`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `result_q` is all zeros after that edge.
- R2: At each rising edge with `rst_n` high, `result_q` takes the value `route ? (mdin + in_e) : mid`. Here `mid = use_sum ? (in_a + in_b) : in_c` and `mdin = use_sum ? in_d : 0`.
- R3: The route signal is `steer_a & (steer_b | zero)`, where `zero` is 1 when the W-bit sum `in_c + in_f` equals 0.
- R4: In the fine style, `a_op0`/`a_op1` equal `in_a`/`in_b` when `use_sum & ~route`, and are all zeros otherwise.
- R5: In the fine style, `b_op0`/`b_op1` equal `mdin`/`in_e` when route is 1, and are all zeros otherwise.
- R6: `b_op0` is all zeros whenever `use_sum` is 0, in both styles. The middle-select mask provides this, and no separate isolation term for that condition is added.
- R7: In the coarse style, the first adder's gate enable is `use_sum` and the second adder's gate enable is `steer_a`. Both are taken directly from the ports.
- R8: `result_q` is identical in both styles for every combination of selects, steering and data.
- R9: While an adder stays isolated over consecutive cycles, its operand taps do not toggle, whatever the data inputs do.
- R10: Both adders produce W-bit results with the carry-out discarded, for example 0xFFFF + 0x0002 = 0x0001 at W = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | W | First adder, operand 0 |
| in_b | input | W | First adder, operand 1 |
| in_c | input | W | Middle-mux bypass word, also local-sum operand |
| in_d | input | W | Second adder operand 0, masked by use_sum |
| in_e | input | W | Second adder operand 1 |
| in_f | input | W | Local-sum operand for the route logic |
| steer_a | input | 1 | Primary steering input A |
| steer_b | input | 1 | Primary steering input B |
| use_sum | input | 1 | Middle-mux select: 1 picks the first adder |
| a_op0 | output | W | Gated operand 0 at the first adder |
| a_op1 | output | W | Gated operand 1 at the first adder |
| b_op0 | output | W | Gated operand 0 at the second adder |
| b_op1 | output | W | Gated operand 1 at the second adder |
| result_q | output | W | Registered result |

## Verification
The hardest case to reach is the route signal going high through the local-sum path alone. This needs `steer_b` low and `in_c + in_f` wrapping to exactly zero. The stimulus sets this up deliberately by choosing `in_f` as the two's complement of `in_c`, so the sum overflows to zero. A second hard case is the gap between the two styles. With `steer_a` high and the route low, the coarse design passes the second adder's operands while the fine design zeroes them, yet both must register the same result. A pseudo-random window then holds each adder isolated across runs of cycles while the data changes, and counts operand toggles.

// File: rtl/opiso_pkg.sv
package opiso_pkg;

    typedef enum logic {
        ISO_FINE   = 1'b0,
        ISO_COARSE = 1'b1
    } iso_style_e;

    typedef struct packed {
        logic route;
        logic en_a;
        logic en_b;
    } iso_ctl_t;

endpackage

// File: rtl/opiso_gate.sv
module opiso_gate #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    always_comb begin
        word_o = word_i & {W{en}};
    end
endmodule

// File: rtl/opiso_adder.sv
module opiso_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    // carry-out dropped by W-bit assignment
    always_comb begin
        sum = x + y;
    end
endmodule

// File: rtl/opiso_steer.sv
module opiso_steer
    import opiso_pkg::*;
#(
    parameter iso_style_e STYLE = ISO_FINE
) (
    input  logic     steer_a,
    input  logic     steer_b,
    input  logic     use_sum,
    input  logic     local_zero,
    output iso_ctl_t ctl
);
    logic route;

    always_comb begin
        route = steer_a & (steer_b | local_zero);
    end

    generate
        if (STYLE == ISO_FINE) begin : g_fine
            always_comb begin
                ctl.route = route;
                // first adder observable only via mid and not overridden
                ctl.en_a  = use_sum & ~route;
                ctl.en_b  = route;
            end
        end else begin : g_coarse
            always_comb begin
                ctl.route = route;
                ctl.en_a  = use_sum;
                ctl.en_b  = steer_a;
            end
        end
    endgenerate
endmodule

// File: rtl/opiso_datapath.sv
module opiso_datapath
    import opiso_pkg::*;
#(
    parameter int         W     = 16,
    parameter iso_style_e STYLE = ISO_FINE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    input  logic [W-1:0] in_d,
    input  logic [W-1:0] in_e,
    input  logic [W-1:0] in_f,
    input  logic         steer_a,
    input  logic         steer_b,
    input  logic         use_sum,
    output logic [W-1:0] a_op0,
    output logic [W-1:0] a_op1,
    output logic [W-1:0] b_op0,
    output logic [W-1:0] b_op1,
    output logic [W-1:0] result_q
);
    localparam logic [W-1:0] ZERO_W = '0;

    typedef struct packed {
        logic [W-1:0] result;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    iso_ctl_t     ctl;
    logic [W-1:0] local_sum;
    logic         local_zero;
    logic [W-1:0] sum_a;
    logic [W-1:0] sum_b;
    logic [W-1:0] mid;
    logic [W-1:0] masked_d;

    // local addition feeding the route logic (never isolated)
    opiso_adder #(.W(W)) u_local (.x(in_c), .y(in_f), .sum(local_sum));

    always_comb begin
        local_zero = (local_sum == ZERO_W);
    end

    opiso_steer #(.STYLE(STYLE)) u_steer (
        .steer_a    (steer_a),
        .steer_b    (steer_b),
        .use_sum    (use_sum),
        .local_zero (local_zero),
        .ctl        (ctl)
    );

    // isolation gates directly in front of the first adder
    opiso_gate #(.W(W)) u_gate_a0 (.en(ctl.en_a), .word_i(in_a), .word_o(a_op0));
    opiso_gate #(.W(W)) u_gate_a1 (.en(ctl.en_a), .word_i(in_b), .word_o(a_op1));

    opiso_adder #(.W(W)) u_add_a (.x(a_op0), .y(a_op1), .sum(sum_a));

    // bit-mask mux already blocks in_d when use_sum is low,
    // so its gate carries only the route term
    always_comb begin
        masked_d = use_sum ? in_d : ZERO_W;
        mid      = use_sum ? sum_a : in_c;
    end

    opiso_gate #(.W(W)) u_gate_b0 (.en(ctl.en_b), .word_i(masked_d), .word_o(b_op0));
    opiso_gate #(.W(W)) u_gate_b1 (.en(ctl.en_b), .word_i(in_e),     .word_o(b_op1));

    opiso_adder #(.W(W)) u_add_b (.x(b_op0), .y(b_op1), .sum(sum_b));

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.result = ZERO_W;
        end else begin
            st_d.result = ctl.route ? sum_b : mid;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        result_q = st_q.result;
    end

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (result_q == ZERO_W));

    // R4
    a_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_sum |-> (a_op0 == ZERO_W && a_op1 == ZERO_W));

    // R5
    b_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !steer_a |-> (b_op0 == ZERO_W && b_op1 == ZERO_W));

    // R6
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_sum |-> (b_op0 == ZERO_W));

    // R2
    bypass_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!steer_a && !use_sum) |=> (result_q == $past(in_c)));

    // R9
    a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_sum && $past(!use_sum)) |-> ($stable(a_op0) && $stable(a_op1)));
endmodule

// File: tb/tb_opiso_datapath.sv
module tb_opiso_datapath;
    import opiso_pkg::*;

    localparam int W = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] in_a, in_b, in_c, in_d, in_e, in_f;
    logic         steer_a, steer_b, use_sum;
    logic [W-1:0] fa0, fa1, fb0, fb1, fres;
    logic [W-1:0] ca0, ca1, cb0, cb1, cres;
    int           errors = 0;
    int           checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opiso_datapath #(.W(W), .STYLE(ISO_FINE)) dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .in_d(in_d), .in_e(in_e), .in_f(in_f), .steer_a(steer_a),
        .steer_b(steer_b), .use_sum(use_sum), .a_op0(fa0), .a_op1(fa1),
        .b_op0(fb0), .b_op1(fb1), .result_q(fres));

    opiso_datapath #(.W(W), .STYLE(ISO_COARSE)) dut_coarse (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .in_d(in_d), .in_e(in_e), .in_f(in_f), .steer_a(steer_a),
        .steer_b(steer_b), .use_sum(use_sum), .a_op0(ca0), .a_op1(ca1),
        .b_op0(cb0), .b_op1(cb1), .result_q(cres));

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_route();
        logic [W-1:0] ls;
        ls = in_c + in_f;
        return steer_a & (steer_b | (ls == '0));
    endfunction

    function automatic logic [W-1:0] m_mdin();
        return use_sum ? in_d : '0;
    endfunction

    function automatic logic [W-1:0] m_out();
        logic [W-1:0] s1, mid;
        s1  = in_a + in_b;
        mid = use_sum ? s1 : in_c;
        return m_route() ? (m_mdin() + in_e) : mid;
    endfunction

    // apply one vector; check taps, then the registered result
    task automatic drive(input string tag,
                         input logic [W-1:0] a, b, c, d, e, f,
                         input logic sa, sb, us);
        logic [W-1:0] exp_out;
        logic         en_a_f, en_b_f;
        @(negedge clk);
        in_a = a; in_b = b; in_c = c; in_d = d; in_e = e; in_f = f;
        steer_a = sa; steer_b = sb; use_sum = us;
        #1;
        en_a_f = use_sum & ~m_route();
        en_b_f = m_route();
        chk({tag, " fine a_op0"}, fa0, en_a_f ? a : '0);
        chk({tag, " fine a_op1"}, fa1, en_a_f ? b : '0);
        chk({tag, " fine b_op0"}, fb0, en_b_f ? m_mdin() : '0);
        chk({tag, " fine b_op1"}, fb1, en_b_f ? e : '0);
        chk({tag, " coarse a_op0"}, ca0, us ? a : '0);
        chk({tag, " coarse a_op1"}, ca1, us ? b : '0);
        chk({tag, " coarse b_op0"}, cb0, sa ? m_mdin() : '0);
        chk({tag, " coarse b_op1"}, cb1, sa ? e : '0);
        exp_out = m_out();
        @(posedge clk);
        #1;
        chk({tag, " fine result"}, fres, exp_out);
        chk({tag, " coarse result"}, cres, exp_out);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        in_a = 16'h1234; in_b = 16'h1111; in_c = 16'h7777; in_d = 16'h0F0F;
        in_e = 16'h2222; in_f = 16'h0001; steer_a = 1'b1; steer_b = 1'b1; use_sum = 1'b1;
        @(posedge clk); #1;
        chk("R1 fine reset", fres, '0);
        chk("R1 coarse reset", cres, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_wrap;
        drive("R10", 16'hFFFF, 16'h0002, 16'h0000, 16'h0, 16'h0, 16'h1, 1'b0, 1'b0, 1'b1);
        chk("R10 wrap value", fres, 16'h0001);
        drive("R10", 16'hFFFF, 16'hFFFF, 16'h0, 16'h8000, 16'h8001, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R10 wrap second adder", fres, 16'h0001);
    endtask

    task automatic t_a_path;
        drive("R4", 16'h0100, 16'h0023, 16'h5555, 16'h0, 16'h0, 16'h1, 1'b0, 1'b1, 1'b1);
        chk("R4 sum passes", fres, 16'h0123);
        drive("R4", 16'h0100, 16'h0023, 16'h5555, 16'h0, 16'h0, 16'h1, 1'b1, 1'b1, 1'b1);
        chk("R4 isolated under route", fa0, '0);
    endtask

    task automatic t_b_path;
        drive("R5", 16'h1, 16'h2, 16'h3, 16'h0040, 16'h0005, 16'h1, 1'b1, 1'b1, 1'b1);
        chk("R5 second adder", fres, 16'h0045);
        drive("R5", 16'h1, 16'h2, 16'h3, 16'h0040, 16'h0005, 16'h1, 1'b1, 1'b0, 1'b0);
        chk("R5 route low bypass", fres, 16'h0003);
    endtask

    task automatic t_local_zero;
        drive("R3", 16'h9, 16'h9, 16'h0005, 16'h0010, 16'h0003, 16'hFFFB, 1'b1, 1'b0, 1'b1);
        chk("R3 local zero routes", fres, 16'h0013);
        drive("R3", 16'h9, 16'h9, 16'h0005, 16'h0010, 16'h0003, 16'hFFFC, 1'b1, 1'b0, 1'b1);
        chk("R3 nonzero local keeps mid", fres, 16'h0012);
        drive("R3", 16'h9, 16'h9, 16'h0005, 16'h0010, 16'h0003, 16'hFFFB, 1'b0, 1'b1, 1'b1);
        chk("R3 steer_a low blocks", fres, 16'h0012);
    endtask

    task automatic t_mask;
        drive("R6", 16'h7, 16'h7, 16'h0, 16'hABCD, 16'h0042, 16'h0, 1'b1, 1'b1, 1'b0);
        chk("R6 masked operand", fb0, '0);
        chk("R6 result is e", fres, 16'h0042);
    endtask

    task automatic t_coarse;
        drive("R7", 16'h0011, 16'h0022, 16'h0100, 16'h0300, 16'h0400, 16'h0001, 1'b1, 1'b0, 1'b1);
        chk("R7 coarse b passes", cb1, 16'h0400);
        chk("R7 fine b isolated", fb1, '0);
        chk("R7 same result", cres, fres);
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 16; k++) begin
            drive("R8", 16'h1000 + 16'(k), 16'h0202, 16'h00F0, 16'h3030, 16'h0505,
                  k[3] ? 16'hFF10 : 16'h0001, k[0], k[1], k[2]);
        end
    endtask

    task automatic t_quiet;
        logic [15:0] lfsr = 16'hACE1;
        logic [W-1:0] pa0, pa1, pb0, pb1;
        logic pia, pib;
        int   toggles = 0;
        pia = 1'b0; pib = 1'b0;
        pa0 = '0; pa1 = '0; pb0 = '0; pb1 = '0;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive("R9", lfsr, ~lfsr, {lfsr[7:0], lfsr[15:8]}, lfsr ^ 16'h5A5A,
                  lfsr + 16'h0101, 16'h0001, (i % 12) >= 6, lfsr[3], (i % 8) < 4);
            if (pia && !(use_sum & ~m_route()) && (fa0 !== pa0 || fa1 !== pa1)) toggles++;
            if (pib && !m_route() && (fb0 !== pb0 || fb1 !== pb1)) toggles++;
            pia = !(use_sum & ~m_route());
            pib = !m_route();
            pa0 = fa0; pa1 = fa1; pb0 = fb0; pb1 = fb1;
        end
        chk("R9 toggles while isolated", W'(toggles), '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_a = '0; in_b = '0; in_c = '0; in_d = '0; in_e = '0; in_f = '0;
        steer_a = 1'b0; steer_b = 1'b0; use_sum = 1'b0;
        t_reset();
        t_wrap();
        t_a_path();
        t_b_path();
        t_local_zero();
        t_mask();
        t_coarse();
        t_sweep();
        t_quiet();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule